// File: doc/BRIEF.md
# Doubled-Pixel VGA Raster Timing Generator

This block drives a 640x480, 60 Hz VGA monitor from a low-resolution source raster in which every source pixel is shown as a 2x2 square of monitor pixels. It counts monitor columns and lines, produces active-low horizontal and vertical sync, and reports whether the current position lies inside the visible screen, inside the doubled source picture, or in the border that surrounds the picture. Inside the picture it also reports which source pixel and source line are being shown, so that a pixel fetch stage can look them up.

The source picture is 256 pixels wide. Doubled, it fills 512 monitor columns, and is centred with 64 border columns on the left and the right. Its height is either 192 or 240 source lines. Doubled, the short picture sits between 48-line borders at the top and bottom, and the tall picture fills the whole height. The height selection is sampled only at a frame boundary, so a frame never changes geometry part-way down.

A scan-line interrupt compares the source line number with a programmed value. When that line begins, it gives a one-cycle pulse and sets a sticky flag. The flag stays set until a clear strobe arrives.

Top module: `vga_fat_timing`

## Requirements
- R1: A line is 800 clocks long, with monitor column h running from 0 to 799. `hsync_n` is low exactly for h from 656 to 751 (96 clocks) and high otherwise.
- R2: A frame is 525 lines long, with monitor line v running from 0 to 524. `vsync_n` is low exactly on lines 490 and 491 and high otherwise.
- R3: `visible` is high exactly when h < 640 and v < 480.
- R4: Horizontally, the picture covers columns 64 to 575. Inside it, `src_x` equals (h - 64) / 2.
- R5: With the latched height at 0 (short), `active` is high on lines 48 to 431 inside the picture columns, and `src_y` equals (v - 48) / 2. With the latched height at 1 (tall), lines 0 to 479 are active and `src_y` equals v / 2.
- R6: `border` is high exactly when `visible` is high and `active` is low.
- R7: `src_x` and `src_y` are both 0 whenever `active` is low.
- R8: `tall_mode` is sampled during reset and on the last clock of each frame (h = 799, v = 524). Changes at any other time have no effect on the geometry until the next frame.
- R9: On the clock with h = 64 on the first, even monitor line of a source line whose number equals `irq_line`, a hit is detected. On the next clock, `irq_pulse` is high for exactly one cycle and `irq_flag` is high.
- R10: `irq_flag` holds its value until `irq_clr` is high on a clock edge without a hit, which clears it. A hit and a clear on the same edge leave the flag set.
- R11: During and right after reset, the position is h = 0 and v = 0, and `irq_flag` and `irq_pulse` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tall_mode | input | 1 | Height selection: 0 for 192 source lines, 1 for 240 source lines |
| irq_line | input | 8 | Source line that raises the interrupt |
| irq_clr | input | 1 | Clear strobe for the interrupt flag |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| visible | output | 1 | Position lies within the 640x480 visible screen |
| active | output | 1 | Position lies inside the doubled source picture |
| border | output | 1 | Visible but outside the picture |
| src_x | output | 8 | Source pixel column, 0 outside the picture |
| src_y | output | 8 | Source line, 0 outside the picture |
| irq_pulse | output | 1 | One-cycle pulse on an interrupt hit |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The assertions check on every cycle the relations between outputs that do not depend on absolute position: sync only while blanked, the picture only inside the visible area, border as the complement of the picture, zeroed coordinates outside the picture, a source column that steps by at most one, and the set, hold and clear rules of the interrupt flag. Exact positions can only be shown by the bench's scenarios. These are the sync and border edges, the centring offsets, the mode taking effect only at a frame boundary after a mid-frame toggle, and the interrupt firing on the right source line, never firing for an out-of-range line, and winning over a clear on the same edge. The bench sweeps every cycle of many frames on a shrunken configuration and checks the full-size timing over the first fifty lines.

// File: rtl/vga_fat_pkg.sv
// Package: shared types for the doubled-pixel VGA timing generator.
// Assumes every source pixel is doubled in both directions (shift by one).
package vga_fat_pkg;

    // Height selection of the source raster
    typedef enum logic {
        HEIGHT_SHORT = 1'b0,
        HEIGHT_TALL  = 1'b1
    } height_mode_e;

    // Log2 of the doubling factor in both directions
    localparam int DOUBLE_SHIFT = 1;

endpackage

// File: rtl/fp_axis_counter.sv
// Module: fp_axis_counter
// Wrapping position counter for one raster axis. It advances when enabled
// and wraps to 0 after TOTAL-1. It assumes TOTAL >= 2.
module fp_axis_counter #(
    parameter int TOTAL = 800,
    parameter int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    output logic [W-1:0] count,
    output logic         last
);
    localparam logic [W-1:0] LAST_VAL = W'(TOTAL - 1);

    assign last = (count == LAST_VAL);

    // Advance or wrap the position on each enabled clock
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (en)
            count <= last ? '0 : count + W'(1);
    end
endmodule

// File: rtl/fp_axis_decode.sv
// Module: fp_axis_decode
// Decodes one axis position into a visible flag and an active-low sync.
// It assumes the order visible, front porch, sync, back porch, starting at 0.
module fp_axis_decode #(
    parameter int ACT  = 640,
    parameter int FP   = 16,
    parameter int SYNC = 96,
    parameter int W    = 10
) (
    input  logic [W-1:0] count,
    output logic         vis,
    output logic         sync_n
);
    localparam logic [W-1:0] SYNC_BEG = W'(ACT + FP);
    localparam logic [W-1:0] SYNC_END = W'(ACT + FP + SYNC);
    localparam logic [W-1:0] ACT_END  = W'(ACT);

    // Visible region and sync window
    always_comb begin
        vis    = (count < ACT_END);
        sync_n = !((count >= SYNC_BEG) && (count < SYNC_END));
    end
endmodule

// File: rtl/fp_raster_map.sv
// Module: fp_raster_map
// Maps a monitor position onto the doubled source raster. It reports the
// picture flag, the source coordinates (0 outside the picture) and the
// line-start point used by the interrupt. It assumes a non-zero horizontal
// border. A zero top border is handled by its own generate variant.
module fp_raster_map
    import vga_fat_pkg::*;
#(
    parameter int H_ACT   = 640,
    parameter int V_ACT   = 480,
    parameter int SRC_W   = 256,
    parameter int SRC_HS  = 192,
    parameter int SRC_HT  = 240,
    parameter int HW      = 10,
    parameter int VW      = 10,
    parameter int XW      = 8,
    parameter int YW      = 8
) (
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    input  height_mode_e  mode,
    output logic          active,
    output logic [XW-1:0] src_x,
    output logic [YW-1:0] src_y,
    output logic          line_start
);
    localparam int H_BORD  = (H_ACT - (SRC_W << DOUBLE_SHIFT)) / 2;
    localparam int VB_S    = (V_ACT - (SRC_HS << DOUBLE_SHIFT)) / 2;
    localparam int VB_T    = (V_ACT - (SRC_HT << DOUBLE_SHIFT)) / 2;
    localparam logic [HW-1:0] H_BEG  = HW'(H_BORD);
    localparam logic [HW-1:0] H_END  = HW'(H_BORD + (SRC_W << DOUBLE_SHIFT));
    localparam logic [VW-1:0] VS_BEG = VW'(VB_S);
    localparam logic [VW-1:0] VS_END = VW'(VB_S + (SRC_HS << DOUBLE_SHIFT));
    localparam logic [VW-1:0] VT_BEG = VW'(VB_T);
    localparam logic [VW-1:0] VT_END = VW'(VB_T + (SRC_HT << DOUBLE_SHIFT));

    logic          h_in;
    logic          in_short;
    logic          in_tall;
    logic          v_in;
    logic [VW-1:0] v_top;
    logic [HW-1:0] h_off;
    logic [VW-1:0] v_off;

    // The short window always has a top border
    assign in_short = (v >= VS_BEG) && (v < VS_END);

    // The tall window either starts at line 0 or has its own border
    generate
        if (VB_T == 0) begin : g_tall_full
            assign in_tall = (v < VT_END);
        end else begin : g_tall_bord
            assign in_tall = (v >= VT_BEG) && (v < VT_END);
        end
    endgenerate

    // Window test, offsets and halved source coordinates
    always_comb begin
        h_in   = (h >= H_BEG) && (h < H_END);
        v_in   = (mode == HEIGHT_TALL) ? in_tall : in_short;
        v_top  = (mode == HEIGHT_TALL) ? VT_BEG : VS_BEG;
        active = h_in && v_in;
        h_off  = h - H_BEG;
        v_off  = v - v_top;
        src_x  = active ? XW'(h_off >> DOUBLE_SHIFT) : '0;
        src_y  = active ? YW'(v_off >> DOUBLE_SHIFT) : '0;
        line_start = active && (h == H_BEG) && !v_off[0];
    end
endmodule

// File: rtl/fp_line_irq.sv
// Module: fp_line_irq
// Scan-line interrupt. A hit is a line start whose source line equals the
// programmed value. A hit gives a one-cycle pulse and sets a sticky flag.
// The clear strobe resets the flag, but a hit on the same edge wins.
module fp_line_irq #(
    parameter int YW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [YW-1:0] src_y,
    input  logic [YW-1:0] irq_line,
    input  logic          irq_clr,
    output logic          hit,
    output logic          irq_pulse,
    output logic          irq_flag
);
    assign hit = line_start && (src_y == irq_line);

    // Register the pulse and update the sticky flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_pulse <= 1'b0;
            irq_flag  <= 1'b0;
        end else begin
            irq_pulse <= hit;
            if (hit)
                irq_flag <= 1'b1;
            else if (irq_clr)
                irq_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/vga_fat_timing.sv
// Module: vga_fat_timing (top)
// 640x480 VGA timing with a doubled, centred source raster and a scan-line
// interrupt. All outputs except the interrupt are decoded from the two
// position counters. The height mode is latched during reset and at the
// last clock of each frame.
module vga_fat_timing
    import vga_fat_pkg::*;
#(
    parameter int H_ACT  = 640,
    parameter int H_FP   = 16,
    parameter int H_SYNC = 96,
    parameter int H_BP   = 48,
    parameter int V_ACT  = 480,
    parameter int V_FP   = 10,
    parameter int V_SYNC = 2,
    parameter int V_BP   = 33,
    parameter int SRC_W  = 256,
    parameter int SRC_HS = 192,
    parameter int SRC_HT = 240,
    localparam int H_TOT = H_ACT + H_FP + H_SYNC + H_BP,
    localparam int V_TOT = V_ACT + V_FP + V_SYNC + V_BP,
    localparam int HW    = $clog2(H_TOT),
    localparam int VW    = $clog2(V_TOT),
    localparam int XW    = $clog2(SRC_W),
    localparam int YW    = $clog2(SRC_HT)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tall_mode,
    input  logic [YW-1:0] irq_line,
    input  logic          irq_clr,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          visible,
    output logic          active,
    output logic          border,
    output logic [XW-1:0] src_x,
    output logic [YW-1:0] src_y,
    output logic          irq_pulse,
    output logic          irq_flag
);
    logic [HW-1:0] h_cnt;
    logic [VW-1:0] v_cnt;
    logic          h_last;
    logic          v_last;
    logic          h_vis;
    logic          v_vis;
    logic          line_start;
    logic          irq_hit_w;
    height_mode_e  mode_q;

    fp_axis_counter #(.TOTAL(H_TOT), .W(HW)) u_hcnt (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .count(h_cnt), .last(h_last)
    );

    fp_axis_counter #(.TOTAL(V_TOT), .W(VW)) u_vcnt (
        .clk(clk), .rst_n(rst_n), .en(h_last), .count(v_cnt), .last(v_last)
    );

    fp_axis_decode #(.ACT(H_ACT), .FP(H_FP), .SYNC(H_SYNC), .W(HW)) u_hdec (
        .count(h_cnt), .vis(h_vis), .sync_n(hsync_n)
    );

    fp_axis_decode #(.ACT(V_ACT), .FP(V_FP), .SYNC(V_SYNC), .W(VW)) u_vdec (
        .count(v_cnt), .vis(v_vis), .sync_n(vsync_n)
    );

    // Latch the height selection in reset and at the frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_q <= height_mode_e'(tall_mode);
        else if (h_last && v_last)
            mode_q <= height_mode_e'(tall_mode);
    end

    fp_raster_map #(
        .H_ACT(H_ACT), .V_ACT(V_ACT), .SRC_W(SRC_W), .SRC_HS(SRC_HS),
        .SRC_HT(SRC_HT), .HW(HW), .VW(VW), .XW(XW), .YW(YW)
    ) u_map (
        .h(h_cnt), .v(v_cnt), .mode(mode_q), .active(active),
        .src_x(src_x), .src_y(src_y), .line_start(line_start)
    );

    fp_line_irq #(.YW(YW)) u_irq (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .src_y(src_y),
        .irq_line(irq_line), .irq_clr(irq_clr), .hit(irq_hit_w),
        .irq_pulse(irq_pulse), .irq_flag(irq_flag)
    );

    // Visible screen and border classification
    always_comb begin
        visible = h_vis && v_vis;
        border  = visible && !active;
    end
endmodule

// File: rtl/fp_timing_chk.sv
// Module: fp_timing_chk
// Checker bound to vga_fat_timing. It holds the relational properties that
// must hold on every cycle, whatever the raster position.
module fp_timing_chk #(
    parameter int XW = 8,
    parameter int YW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          visible,
    input logic          active,
    input logic          border,
    input logic [XW-1:0] src_x,
    input logic [YW-1:0] src_y,
    input logic          irq_clr,
    input logic          irq_pulse,
    input logic          irq_flag,
    input logic          hit
);
    logic seen;

    // Mark the cycles after the first clock out of reset
    always_ff @(posedge clk) begin
        if (!rst_n) seen <= 1'b0;
        else        seen <= 1'b1;
    end

    p_hsync_blank_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n |-> !visible);
    p_vsync_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n |-> !visible);
    p_active_vis_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> visible);
    p_border_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        border |-> (visible && !active));
    p_src_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !active |-> (src_x == '0 && src_y == '0));
    p_xstep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seen && active && $past(active)) |->
        (src_x == $past(src_x) || src_x == $past(src_x) + XW'(1)));
    p_irq_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (irq_flag && irq_pulse));
    p_pulse_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);
    p_flag_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_flag && !irq_clr) |=> irq_flag);
    p_flag_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !hit) |=> !irq_flag);
endmodule

bind vga_fat_timing fp_timing_chk #(.XW(XW), .YW(YW)) u_chk (
    .clk(clk), .rst_n(rst_n), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .visible(visible), .active(active), .border(border), .src_x(src_x),
    .src_y(src_y), .irq_clr(irq_clr), .irq_pulse(irq_pulse),
    .irq_flag(irq_flag), .hit(irq_hit_w)
);

// File: tb/tb_vga_fat_timing.sv
// Bench: sweeps every cycle of a shrunken raster (56x37, 16x10 or 16x15
// source) over many frames, and the full-size raster over its first 50 lines.
module tb_vga_fat_timing;
    // Shrunken configuration
    localparam int SHA = 40, SHF = 4, SHS = 6, SHB = 6;
    localparam int SVA = 30, SVF = 2, SVS = 2, SVB = 3;
    localparam int SSW = 16, SSS = 10, SST = 15;
    localparam int SHT = SHA + SHF + SHS + SHB;
    localparam int SVT = SVA + SVF + SVS + SVB;
    localparam int SFR = SHT * SVT;
    localparam int NCYC = 40000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic       s_tall = 1'b1, s_clr = 1'b0;
    logic [3:0] s_line = '0;
    logic       s_hs, s_vs, s_vis, s_act, s_bord, s_pulse, s_flag;
    logic [3:0] s_sx, s_sy;

    logic       f_hs, f_vs, f_vis, f_act, f_bord, f_pulse, f_flag;
    logic [7:0] f_sx, f_sy;

    vga_fat_timing #(
        .H_ACT(SHA), .H_FP(SHF), .H_SYNC(SHS), .H_BP(SHB),
        .V_ACT(SVA), .V_FP(SVF), .V_SYNC(SVS), .V_BP(SVB),
        .SRC_W(SSW), .SRC_HS(SSS), .SRC_HT(SST)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tall_mode(s_tall), .irq_line(s_line),
        .irq_clr(s_clr), .hsync_n(s_hs), .vsync_n(s_vs), .visible(s_vis),
        .active(s_act), .border(s_bord), .src_x(s_sx), .src_y(s_sy),
        .irq_pulse(s_pulse), .irq_flag(s_flag)
    );

    vga_fat_timing dut_full (
        .clk(clk), .rst_n(rst_n), .tall_mode(1'b0), .irq_line(8'd0),
        .irq_clr(1'b0), .hsync_n(f_hs), .vsync_n(f_vs), .visible(f_vis),
        .active(f_act), .border(f_bord), .src_x(f_sx), .src_y(f_sy),
        .irq_pulse(f_pulse), .irq_flag(f_flag)
    );

    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected outputs for a position, computed from the requirements
    task automatic expect_pos(input int h, v, mode, ha, hf, hs, sw, va, vf, vs, shs, sht,
                              output int e_hs, e_vs, e_vis, e_act, e_bord, e_sx, e_sy, e_st);
        int hb, sh, vb;
        bit hin, vin;
        hb = (ha - 2 * sw) / 2;
        sh = mode ? sht : shs;
        vb = (va - 2 * sh) / 2;
        e_vis = (h < ha && v < va) ? 1 : 0;
        e_hs  = (h >= ha + hf && h < ha + hf + hs) ? 0 : 1;
        e_vs  = (v >= va + vf && v < va + vf + vs) ? 0 : 1;
        hin = (h >= hb && h < hb + 2 * sw);
        vin = (v >= vb && v < vb + 2 * sh);
        e_act  = (hin && vin) ? 1 : 0;
        e_bord = (e_vis == 1 && e_act == 0) ? 1 : 0;
        e_sx = e_act ? (h - hb) / 2 : 0;
        e_sy = e_act ? (v - vb) / 2 : 0;
        e_st = (e_act == 1 && h == hb && ((v - vb) % 2) == 0) ? 1 : 0;
    endtask

    initial begin
        int exp_mode, exp_flag, exp_pulse;
        exp_mode = 1; exp_flag = 0; exp_pulse = 0;
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(s_flag == 1'b0, "R11 flag in reset", s_flag, 0);
        chk(s_pulse == 1'b0, "R11 pulse in reset", s_pulse, 0);
        chk(s_vis == 1'b1 && s_hs == 1'b1 && s_vs == 1'b1, "R11 position 0 in reset", s_vis, 1);
        chk(s_bord == 1'b1 && s_sx == 4'd0, "R11 border at origin", s_bord, 1);
        rst_n = 1'b1;
        for (int n = 0; n < NCYC; n++) begin
            int h, v, f, p, hf, vf;
            int e_hs, e_vs, e_vis, e_act, e_bord, e_sx, e_sy, e_st;
            bit hit;
            h = n % SHT; v = (n / SHT) % SVT; f = n / SFR; p = n % SFR;
            // drive level inputs for this cycle
            if (p == 0) s_line = 4'((f * 3) % 16);
            if (p == 500) s_tall = ~s_tall;                 // R8: mid-frame toggle, ignored
            if (p == 1000) s_tall = ((f + 1) % 3) != 0;
            expect_pos(h, v, exp_mode, SHA, SHF, SHS, SSW, SVA, SVF, SVS, SSS, SST,
                       e_hs, e_vs, e_vis, e_act, e_bord, e_sx, e_sy, e_st);
            chk(s_hs == 1'(e_hs), "R1 hsync_n", s_hs, e_hs);
            chk(s_vs == 1'(e_vs), "R2 vsync_n", s_vs, e_vs);
            chk(s_vis == 1'(e_vis), "R3 visible", s_vis, e_vis);
            chk(s_act == 1'(e_act), "R5/R8 active", s_act, e_act);
            chk(s_bord == 1'(e_bord), "R6 border", s_bord, e_bord);
            chk(int'(s_sx) == e_sx, "R4 src_x", s_sx, e_sx);
            chk(int'(s_sy) == e_sy, "R5/R8 src_y", s_sy, e_sy);
            if (e_act == 0) chk(s_sx == 0 && s_sy == 0, "R7 zero outside picture", s_sy, 0);
            chk(int'(s_pulse) == exp_pulse, "R9 irq_pulse", s_pulse, exp_pulse);
            chk(int'(s_flag) == exp_flag, "R10 irq_flag", s_flag, exp_flag);
            hit = (e_st == 1) && (e_sy == int'(s_line));
            // R10: clears every frame, plus a clear on the hit edge in some frames
            s_clr = (p == 10) || (p == 1500) || ((f % 4) == 1 && hit);
            // full-size instance
            hf = n % 800; vf = (n / 800) % 525;
            expect_pos(hf, vf, 0, 640, 16, 96, 256, 480, 10, 2, 192, 240,
                       e_hs, e_vs, e_vis, e_act, e_bord, e_sx, e_sy, e_st);
            chk(f_hs == 1'(e_hs), "R1 full hsync_n", f_hs, e_hs);
            chk(f_vs == 1'(e_vs), "R2 full vsync_n", f_vs, e_vs);
            chk(f_vis == 1'(e_vis), "R3 full visible", f_vis, e_vis);
            chk(f_act == 1'(e_act), "R5 full active", f_act, e_act);
            chk(f_bord == 1'(e_bord), "R6 full border", f_bord, e_bord);
            chk(int'(f_sx) == e_sx, "R4 full src_x", f_sx, e_sx);
            chk(int'(f_sy) == e_sy, "R5 full src_y", f_sy, e_sy);
            // next-state expectations
            if (p == SFR - 1) exp_mode = int'(s_tall);
            exp_pulse = hit ? 1 : 0;
            if (hit) exp_flag = 1;
            else if (s_clr) exp_flag = 0;
            @(posedge clk);
            @(negedge clk);
        end
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check
    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule